// File: doc/BRIEF.md
# AM824 Consumer-Audio Label Generator

This block turns a stream of 16-bit audio samples into 32-bit AM824 event quadlets for an isochronous audio transmitter. Each accepted sample is widened to a 24-bit field, and an 8-bit label is placed above it. In the consumer digital-audio (IEC 60958) formats the label carries the per-subframe control bits that a receiver needs to rebuild the interface stream: block start, subframe marker, parity and one channel-status bit. In raw multichannel mode the label is a fixed code and any channel index is accepted.

The generator keeps the position inside the 192-frame channel-status block. An event-advance strobe from the packer moves it on once per event, after the last channel of that event. The channel-status bit is taken from the position: a compressed-data flag, two fixed ones, and a four-bit sample-rate code spread over four consecutive frames. A change of format restarts the block. Each quadlet leaves on a registered output one cycle after its sample, with the label in the most significant byte so that it is the first byte on a big-endian bus.

Top module: `am824_labeler`

## Requirements
- R1: The block position counts 0 to 191. It moves on by one on each cycle with `evt_adv_i` high and wraps from 191 to 0. Samples taken in a cycle use the position held before that cycle's advance.
- R2: In both consumer formats the channel-status bit (quadlet bit 26) is 1 at position 1 only in compressed format, 1 at positions 2 and 9, and rate-code bit (27 − position) at positions 24 to 27. It is 0 at every other position.
- R3: The rate code comes from `rate_i` (0=32 kHz, 1=44.1, 2=48, 3=88.2, 4=96, 5=176.4, 6=192 kHz): 4'hC for 32 kHz, 4'h4 for 48 kHz and 4'h0 for every other rate.
- R4: In both consumer formats the parity bit (quadlet bit 27) makes the XOR of quadlet bits 27, 26 and 23:0 equal to zero.
- R5: In both consumer formats quadlet bit 28 is 1 exactly when `chan_i` is 0. Quadlet bit 29 is 1 exactly when `chan_i` is 0 and the position is 0. Quadlet bits 31:30 and 25:24 are 0.
- R6: With `fmt_i` equal to 0 (raw) or 3, the label (quadlet bits 31:24) is 8'h40 for any channel index.
- R7: In a consumer format a sample with `chan_i` greater than 1 is dropped. No quadlet is produced for it and the position is not affected.
- R8: For an accepted sample, `quad_vld_o` is high in the next cycle, quadlet bits 23:8 hold `smp_le_i` (high byte in 23:16, low byte in 15:8) and bits 7:0 are 0. With no accepted sample `quad_vld_o` is low.
- R9: An active-low `rst_n` clears the position to 0 and `quad_vld_o` and `quad_o` to 0, and the format history to raw.
- R10: A cycle whose `fmt_i` (0=raw, 1=consumer PCM, 2=consumer compressed, 3=raw) differs from the previous cycle's value restarts the block. Samples in that cycle use position 0, that cycle's advance is ignored, and the position is 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fmt_i | input | 2 | Stream format: 0 raw, 1 consumer PCM, 2 consumer compressed, 3 raw |
| rate_i | input | 3 | Sample-rate select, used for the rate code |
| smp_vld_i | input | 1 | Sample present this cycle |
| smp_le_i | input | 16 | Sample, low byte in bits 7:0 |
| chan_i | input | 4 | Channel (subframe) index of the sample |
| evt_adv_i | input | 1 | End of event: advance the block position |
| quad_vld_o | output | 1 | Quadlet valid |
| quad_o | output | 32 | Event quadlet, label in bits 31:24 |

## Verification
On every cycle the assertions check the counter range, wrap, hold and restart behaviour, the parity balance and the label shape of each consumer quadlet, the raw label, the zero low byte and the dropping of out-of-range channels. Only the bench scenarios can show that the channel-status bit lands on the right positions for each rate and format over full 192-frame blocks. The same applies to the sample bytes arriving unchanged, the restart on a format change with a sample in the same cycle, and the recovery from a reset taken mid-stream.

// File: rtl/am824_pkg.sv
package am824_pkg;

  typedef enum logic [1:0] {
    FMT_RAW   = 2'd0,
    FMT_PCM   = 2'd1,
    FMT_COMP  = 2'd2,
    FMT_RAW_B = 2'd3
  } fmt_e;

  localparam int unsigned LBL_W      = 8;
  localparam int unsigned FIELD_W    = 24;
  localparam int unsigned QUAD_W     = LBL_W + FIELD_W;
  localparam int unsigned RCODE_W    = 4;
  localparam logic [LBL_W-1:0] RAW_LABEL = 8'h40;

  localparam logic [2:0] RATE_32K = 3'd0;
  localparam logic [2:0] RATE_48K = 3'd2;
  localparam logic [RCODE_W-1:0] RCODE_32K = 4'hC;
  localparam logic [RCODE_W-1:0] RCODE_48K = 4'h4;
  localparam logic [RCODE_W-1:0] RCODE_DEF = 4'h0;

  localparam int unsigned CS_COMP_POS  = 1;
  localparam int unsigned CS_ONE_POS_A = 2;
  localparam int unsigned CS_ONE_POS_B = 9;
  localparam int unsigned CS_RATE_POS  = 24;

  function automatic logic is_consumer(input logic [1:0] f);
    return (f == FMT_PCM) || (f == FMT_COMP);
  endfunction

endpackage

// File: rtl/am824_frame_ctr.sv
module am824_frame_ctr #(
  parameter int unsigned FRAMES = 192,
  localparam int unsigned FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [FRM_W-1:0] frame_o
);

  localparam logic [FRM_W-1:0] LAST = FRM_W'(FRAMES - 1);

  logic [FRM_W-1:0] frame_q;
  logic [FRM_W-1:0] frame_nxt;
  logic             frame_en;

  always_comb begin
    frame_en  = clr_i | adv_i;
    frame_nxt = frame_q;
    if (clr_i) begin
      frame_nxt = '0;
    end else if (adv_i) begin
      if (frame_q == LAST) frame_nxt = '0;
      else                 frame_nxt = frame_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_en) begin
      frame_q <= frame_nxt;
    end
  end

  assign frame_o = frame_q;

  // R1
  frm_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q <= LAST);

  // R1
  frm_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && frame_q == LAST) |=> frame_q == '0);

  // R1
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(frame_q));

  // R10
  frm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> frame_q == '0);

endmodule

// File: rtl/am824_cs_sel.sv
module am824_cs_sel
  import am824_pkg::*;
#(
  parameter int unsigned FRM_W = 8
) (
  input  logic [FRM_W-1:0] pos_i,
  input  logic [1:0]       fmt_i,
  input  logic [2:0]       rate_i,
  output logic             cs_o
);

  logic [RCODE_W-1:0] rcode;
  logic [1:0]         rbit_idx;
  logic               in_rate_win;

  always_comb begin
    unique case (rate_i)
      RATE_32K: rcode = RCODE_32K;
      RATE_48K: rcode = RCODE_48K;
      default:  rcode = RCODE_DEF;
    endcase
  end

  // positions 24..27 map to rate-code bits 3..0
  assign in_rate_win = (pos_i >= FRM_W'(CS_RATE_POS)) &&
                       (pos_i <  FRM_W'(CS_RATE_POS + RCODE_W));
  assign rbit_idx    = ~pos_i[1:0];

  always_comb begin
    cs_o = 1'b0;
    if (pos_i == FRM_W'(CS_COMP_POS)) begin
      cs_o = (fmt_i == FMT_COMP);
    end else if (pos_i == FRM_W'(CS_ONE_POS_A) || pos_i == FRM_W'(CS_ONE_POS_B)) begin
      cs_o = 1'b1;
    end else if (in_rate_win) begin
      cs_o = rcode[rbit_idx];
    end
  end

endmodule

// File: rtl/am824_label_fmt.sv
module am824_label_fmt
  import am824_pkg::*;
#(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned CH_W  = 4,
  parameter int unsigned FRM_W = 8,
  localparam int unsigned PAD_W = FIELD_W - SMP_W
) (
  input  logic [SMP_W-1:0]  smp_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [1:0]        fmt_i,
  input  logic [FRM_W-1:0]  pos_i,
  input  logic              cs_i,
  output logic              accept_o,
  output logic [QUAD_W-1:0] quad_o
);

  logic [FIELD_W-1:0] field;
  logic [LBL_W-1:0]   label;
  logic               consumer;
  logic               sub0;
  logic               blk_start;
  logic               parity;

  assign consumer  = is_consumer(fmt_i);
  assign field     = {smp_i, {PAD_W{1'b0}}};
  assign sub0      = (chan_i == '0);
  assign blk_start = sub0 && (pos_i == '0);
  assign parity    = (^field) ^ cs_i;
  assign accept_o  = !consumer || (chan_i < CH_W'(2));

  always_comb begin
    if (consumer) begin
      label    = '0;
      label[5] = blk_start;
      label[4] = sub0;
      label[3] = parity;
      label[2] = cs_i;
    end else begin
      label = RAW_LABEL;
    end
  end

  assign quad_o = {label, field};

endmodule

// File: rtl/am824_labeler.sv
module am824_labeler
  import am824_pkg::*;
#(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned CH_W   = 4,
  localparam int unsigned FRM_W = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_i,
  input  logic [2:0]        rate_i,
  input  logic              smp_vld_i,
  input  logic [SMP_W-1:0]  smp_le_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              evt_adv_i,
  output logic              quad_vld_o,
  output logic [QUAD_W-1:0] quad_o
);

  logic [1:0]        fmt_q;
  logic              fmt_chg;
  logic [FRM_W-1:0]  frame;
  logic [FRM_W-1:0]  pos;
  logic              cs_bit;
  logic              accept;
  logic [QUAD_W-1:0] quad_nxt;
  logic              vld_nxt;
  logic              quad_en;

  assign fmt_chg = (fmt_i != fmt_q);
  assign pos     = fmt_chg ? '0 : frame;

  am824_frame_ctr #(.FRAMES(FRAMES)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (evt_adv_i),
    .clr_i   (fmt_chg),
    .frame_o (frame)
  );

  am824_cs_sel #(.FRM_W(FRM_W)) u_cs (
    .pos_i  (pos),
    .fmt_i  (fmt_i),
    .rate_i (rate_i),
    .cs_o   (cs_bit)
  );

  am824_label_fmt #(.SMP_W(SMP_W), .CH_W(CH_W), .FRM_W(FRM_W)) u_lbl (
    .smp_i    (smp_le_i),
    .chan_i   (chan_i),
    .fmt_i    (fmt_i),
    .pos_i    (pos),
    .cs_i     (cs_bit),
    .accept_o (accept),
    .quad_o   (quad_nxt)
  );

  assign vld_nxt = smp_vld_i && accept;
  assign quad_en = vld_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_RAW;
    end else begin
      fmt_q <= fmt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_vld_o <= 1'b0;
    end else begin
      quad_vld_o <= vld_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_o <= '0;
    end else if (quad_en) begin
      quad_o <= quad_nxt;
    end
  end

  // R4
  parity_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_vld_o && !quad_o[30]) |-> ((^quad_o[23:0]) ^ quad_o[27] ^ quad_o[26]) == 1'b0);

  // R5
  blk_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quad_vld_o && !quad_o[30]) |-> (!quad_o[29] || quad_o[28]) && !quad_o[31]
                                     && quad_o[25:24] == 2'b00);

  // R6
  raw_label_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !is_consumer(fmt_i)) |=> quad_vld_o && quad_o[31:24] == RAW_LABEL);

  // R7
  chan_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && is_consumer(fmt_i) && chan_i > CH_W'(1)) |=> !quad_vld_o);

  // R8
  low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quad_vld_o |-> quad_o[7:0] == 8'h00);

  // R8
  smp_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld_i && !is_consumer(fmt_i)) |=> quad_o[23:8] == $past(smp_le_i));

endmodule

// File: tb/tb_am824_labeler.sv
module tb_am824_labeler;

  logic        clk;
  logic        rst_n;
  logic [1:0]  fmt_i;
  logic [2:0]  rate_i;
  logic        smp_vld_i;
  logic [15:0] smp_le_i;
  logic [3:0]  chan_i;
  logic        evt_adv_i;
  logic        quad_vld_o;
  logic [31:0] quad_o;

  int n_chk;
  int n_fail;
  int mdl_frame;
  logic [1:0] mdl_prev_fmt;
  bit done;

  am824_labeler dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .rate_i(rate_i),
    .smp_vld_i(smp_vld_i), .smp_le_i(smp_le_i), .chan_i(chan_i),
    .evt_adv_i(evt_adv_i), .quad_vld_o(quad_vld_o), .quad_o(quad_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit consumer(input logic [1:0] f);
    return (f == 2'd1) || (f == 2'd2);
  endfunction

  function automatic logic [3:0] rcode(input logic [2:0] r);
    if (r == 3'd0) return 4'hC;
    if (r == 3'd2) return 4'h4;
    return 4'h0;
  endfunction

  function automatic logic exp_cs(input logic [1:0] f, input logic [2:0] r, input int pos);
    logic [3:0] c;
    c = rcode(r);
    if (pos == 1) return (f == 2'd2);
    if (pos == 2 || pos == 9) return 1'b1;
    if (pos >= 24 && pos <= 27) return c[27 - pos];
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_quad(input logic [1:0] f, input logic [2:0] r,
                                           input int pos, input logic [3:0] ch,
                                           input logic [15:0] s);
    logic [23:0] fld;
    logic [7:0]  lbl;
    logic        cs;
    fld = {s[15:8], s[7:0], 8'h00};
    if (!consumer(f)) return {8'h40, fld};
    cs  = exp_cs(f, r, pos);
    lbl = 8'h00;
    lbl[5] = (ch == 0) && (pos == 0);
    lbl[4] = (ch == 0);
    lbl[3] = (^fld) ^ cs;
    lbl[2] = cs;
    return {lbl, fld};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check result one edge later
  task automatic step(input bit v, input logic [3:0] ch, input logic [15:0] s,
                      input bit adv, input string req);
    bit chg, acc;
    int pos;
    logic [31:0] e;
    smp_vld_i = v; chan_i = ch; smp_le_i = s; evt_adv_i = adv;
    chg = (fmt_i != mdl_prev_fmt);
    pos = chg ? 0 : mdl_frame;
    acc = v && (!consumer(fmt_i) || ch < 2);
    e   = exp_quad(fmt_i, rate_i, pos, ch, s);
    @(posedge clk);
    if (chg) mdl_frame = 0;
    else if (adv) mdl_frame = (pos == 191) ? 0 : pos + 1;
    mdl_prev_fmt = fmt_i;
    @(negedge clk);
    chk(quad_vld_o == acc, req, {31'd0, quad_vld_o}, {31'd0, acc});
    if (acc) chk(quad_o == e, req, quad_o, e);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    smp_vld_i = 1'b0; evt_adv_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(quad_vld_o == 1'b0, "R9", {31'd0, quad_vld_o}, 32'd0);
    chk(quad_o == 32'd0, "R9", quad_o, 32'd0);
    mdl_frame = 0;
    mdl_prev_fmt = 2'd0;
    rst_n = 1'b1;
    @(negedge clk);
    mdl_prev_fmt = fmt_i;
    mdl_frame = 0;
  endtask

  task automatic stereo_events(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 4'd0, 16'($urandom), 1'b0, req);
      step(1'b1, 4'd1, 16'($urandom), 1'b1, req);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    void'($urandom(32'd1974));
    fmt_i = 2'd1; rate_i = 3'd0;
    smp_vld_i = 0; smp_le_i = '0; chan_i = '0; evt_adv_i = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(quad_vld_o == 1'b0, "R9", {31'd0, quad_vld_o}, 32'd0);
    do_reset();
    // R1 R2 R3 R4 R5 R8: 32 kHz PCM over more than one block, with wrap
    stereo_events(200, "R1/R2/R3/R4/R5/R8 pcm32k");
    // R3: 44.1 and 192 kHz carry code 0, 48 kHz code 4
    rate_i = 3'd1; stereo_events(40, "R3 44k1");
    rate_i = 3'd6; stereo_events(40, "R3 192k");
    rate_i = 3'd2; stereo_events(40, "R3 48k");
    // R10: format change with a sample in the change cycle
    fmt_i = 2'd2;
    step(1'b1, 4'd0, 16'h1234, 1'b1, "R10 restart");
    step(1'b1, 4'd1, 16'h00FF, 1'b1, "R10 restart");
    stereo_events(30, "R2 compressed flag");
    // R4 parity corners
    step(1'b1, 4'd0, 16'hFFFF, 1'b0, "R4 all ones");
    step(1'b1, 4'd1, 16'h0000, 1'b1, "R4 all zero");
    // R7: out-of-range channels dropped, position untouched
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 4'(2 + ($urandom % 14)), 16'($urandom), 1'b0, "R7 drop");
    end
    stereo_events(5, "R7 position kept");
    // R6: raw mode, any channel
    fmt_i = 2'd0;
    for (int i = 0; i < 40; i++) begin
      for (int c = 0; c < 8; c++) step(1'b1, 4'(c), 16'($urandom), c == 7, "R6 raw");
    end
    fmt_i = 2'd3;
    for (int i = 0; i < 10; i++) step(1'b1, 4'($urandom), 16'($urandom), 1'b1, "R6 raw code3");
    // R8: idle cycles produce no quadlet
    for (int i = 0; i < 4; i++) step(1'b0, 4'd0, 16'hABCD, 1'b0, "R8 idle");
    // R10 then R9: mid-block reset
    fmt_i = 2'd1; rate_i = 3'd0;
    stereo_events(13, "R10 back to pcm");
    do_reset();
    stereo_events(30, "R9 after reset");
    // random mixed traffic
    for (int i = 0; i < 600; i++) begin
      step($urandom % 4 != 0, 4'($urandom % 3), 16'($urandom), $urandom % 2, "R1/R2/R4/R5 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule